// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block times single programmed-I/O transfers on a parallel ATA channel that carries two drives. A requester names the target drive (0 or 1) and the direction. The block then runs three counted phases. The first is an address-setup phase. The second is a data phase, during which the read or write strobe is high. The last is a recovery phase. The block ends the cycle with a one-clock done pulse. Every phase length is a whole number of bus clocks.

Two timing sets, A and B, hold the data-phase and recovery counts. Each set has separate fields for reads and for writes. A mapping input chooses which set serves which drive. The address-setup count is not kept per set. It comes from two per-drive setup requirements, and the larger of the two is used, because both drives share one setup timing. All counts are captured when a request is accepted, so the settings may change while a cycle runs without affecting it.

The request is a level. The requester holds `req` high until it sees `busy` rise. A request raised while a cycle is running stays pending until the channel returns to idle, so it is delayed but never lost.

The controller has four states:
- `ST_IDLE` goes to `ST_SETUP` on a request (accept).
- `ST_SETUP` goes to `ST_DATA` when its count expires.
- `ST_DATA` goes to `ST_RECOV` when its count expires.
- `ST_RECOV` goes to `ST_IDLE` when its count expires. The done pulse is issued in that last recovery clock.

In every other case a state holds and counts down.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset the block is in `ST_IDLE`: `busy`, `strb_rd`, `strb_wr` and `done` are low, and they stay low for as long as `req` stays low.
- R2: A request seen high on a clock edge in `ST_IDLE` is accepted, and `busy` is high from the next cycle. `busy` then stays high for exactly setup + data + recovery clocks.
- R3: The setup phase lasts 1 + max(`setup_d0`, `setup_d1`) clocks (2-bit fields, 1 to 4 clocks), whichever drive is addressed.
- R4: The data phase lasts 1 + data field clocks (4-bit field, 1 to 16 clocks). `strb_rd` is high through the whole phase when `req_wr`=0 was accepted, and `strb_wr` is high when `req_wr`=1 was accepted.
- R5: The recovery phase lasts 2 + recovery field clocks (4-bit field, 2 to 17 clocks), with both strobes low.
- R6: With `swap_sets`=0, drive 0 (`req_sel`=0) uses `tset_a` and drive 1 uses `tset_b`. With `swap_sets`=1 the mapping is reversed.
- R7: The layout of a timing set is: bits [15:12] read data, bits [11:8] read recovery, bits [7:4] write data, bits [3:0] write recovery. The accepted direction chooses which pair is used.
- R8: `done` is high for exactly one clock per cycle, in the last recovery clock. The next cycle is `ST_IDLE`.
- R9: A request raised during a cycle is not started before that cycle ends. One idle clock follows `done`, and then the pending request starts with the drive and direction presented when it is accepted.
- R10: Timing inputs and the mapping input are sampled only at acceptance. Changing them during a cycle does not alter that cycle's phase lengths.
- R11: The two strobes are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held high until accepted |
| req_sel | input | 1 | Target drive: 0 or 1 |
| req_wr | input | 1 | Direction: 1 write, 0 read |
| swap_sets | input | 1 | 0: set A for drive 0, set B for drive 1; 1: reversed |
| setup_d0 | input | 2 | Setup requirement of drive 0, clocks minus one |
| setup_d1 | input | 2 | Setup requirement of drive 1, clocks minus one |
| tset_a | input | 16 | Timing set A (read data, read recovery, write data, write recovery) |
| tset_b | input | 16 | Timing set B, same layout |
| busy | output | 1 | Cycle in progress |
| strb_rd | output | 1 | Read strobe, high during the data phase of a read |
| strb_wr | output | 1 | Write strobe, high during the data phase of a write |
| done | output | 1 | One-clock pulse in the last recovery clock |

## Verification
The properties check these on every clock:
- the two strobes are mutually exclusive, and neither is high while `busy` is low;
- `done` is followed by idle;
- `busy` only rises after a request;
- a strobe is always preceded by at least one setup clock, and `done` by at least one strobe-free recovery clock;
- no busy period exceeds the longest legal cycle.

The exact phase lengths need the directed scenarios. These include the max-of-two setup rule, the set mapping with and without swap, the read/write field choice, the held-off back-to-back request, and the snapshot taken at acceptance.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_RECOV = 2'd3
    } phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pio_setup_merge.sv
module pio_setup_merge #(
    parameter int SETUP_W = 2,
    parameter int CNT_W   = 5
) (
    input  logic [SETUP_W-1:0] setup_d0,
    input  logic [SETUP_W-1:0] setup_d1,
    output logic [CNT_W-1:0]   setup_rl
);
    // Both drives share one setup timing, so the slower one decides.
    logic [SETUP_W-1:0] wider;

    always_comb begin
        wider    = (setup_d0 > setup_d1) ? setup_d0 : setup_d1;
        setup_rl = CNT_W'(wider);
    end
endmodule

// File: rtl/pio_set_select.sv
module pio_set_select #(
    parameter int DATA_W = 4,
    parameter int REC_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic                         req_sel,
    input  logic                         req_wr,
    input  logic                         swap_sets,
    input  logic [2*DATA_W+2*REC_W-1:0]  tset_a,
    input  logic [2*DATA_W+2*REC_W-1:0]  tset_b,
    output logic [CNT_W-1:0]             data_rl,
    output logic [CNT_W-1:0]             rec_rl
);
    localparam int SET_W    = 2*DATA_W + 2*REC_W;
    localparam int WR_REC_LO = 0;
    localparam int WR_DAT_LO = REC_W;
    localparam int RD_REC_LO = REC_W + DATA_W;
    localparam int RD_DAT_LO = 2*REC_W + DATA_W;

    logic [SET_W-1:0]  chosen;
    logic [DATA_W-1:0] dat_f;
    logic [REC_W-1:0]  rec_f;

    always_comb begin
        chosen = (req_sel ^ swap_sets) ? tset_b : tset_a;
        if (req_wr) begin
            dat_f = chosen[WR_DAT_LO +: DATA_W];
            rec_f = chosen[WR_REC_LO +: REC_W];
        end else begin
            dat_f = chosen[RD_DAT_LO +: DATA_W];
            rec_f = chosen[RD_REC_LO +: REC_W];
        end
        // Reload values are the phase length minus one.
        data_rl = CNT_W'(dat_f);
        rec_rl  = CNT_W'(rec_f) + CNT_W'(1);
    end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_timer_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] setup_rl,
    input  logic [CNT_W-1:0] data_rl,
    input  logic [CNT_W-1:0] rec_rl,
    output logic             busy,
    output logic             strb_rd,
    output logic             strb_wr,
    output logic             done
);
    phase_e           state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             wr_q;
    logic [CNT_W-1:0] data_q, rec_q;
    logic             accept;
    logic             last;

    assign accept = (state == ST_IDLE) && req;
    assign last   = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            data_q <= '0;
            rec_q  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (accept) begin
                wr_q   <= req_wr;
                data_q <= data_rl;
                rec_q  <= rec_rl;
            end
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = setup_rl;
                end
            end
            ST_SETUP: begin
                if (last) begin
                    state_nx = ST_DATA;
                    cnt_nx   = data_q;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (last) begin
                    state_nx = ST_RECOV;
                    cnt_nx   = rec_q;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_RECOV: begin
                if (last) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        strb_rd = 1'b0;
        strb_wr = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: ;
            ST_DATA: begin
                strb_rd = ~wr_q;
                strb_wr = wr_q;
            end
            ST_RECOV: done = last;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int SETUP_W = 2,
    parameter int DATA_W  = 4,
    parameter int REC_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        req_sel,
    input  logic                        req_wr,
    input  logic                        swap_sets,
    input  logic [SETUP_W-1:0]          setup_d0,
    input  logic [SETUP_W-1:0]          setup_d1,
    input  logic [2*DATA_W+2*REC_W-1:0] tset_a,
    input  logic [2*DATA_W+2*REC_W-1:0] tset_b,
    output logic                        busy,
    output logic                        strb_rd,
    output logic                        strb_wr,
    output logic                        done
);
    // Recovery reload reaches 2**REC_W, hence one extra bit there.
    localparam int CNT_W = max3(SETUP_W, DATA_W, REC_W + 1);

    logic [CNT_W-1:0] setup_rl, data_rl, rec_rl;

    pio_setup_merge #(.SETUP_W(SETUP_W), .CNT_W(CNT_W)) u_merge (
        .setup_d0 (setup_d0),
        .setup_d1 (setup_d1),
        .setup_rl (setup_rl)
    );

    pio_set_select #(.DATA_W(DATA_W), .REC_W(REC_W), .CNT_W(CNT_W)) u_select (
        .req_sel   (req_sel),
        .req_wr    (req_wr),
        .swap_sets (swap_sets),
        .tset_a    (tset_a),
        .tset_b    (tset_b),
        .data_rl   (data_rl),
        .rec_rl    (rec_rl)
    );

    pio_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .setup_rl (setup_rl),
        .data_rl  (data_rl),
        .rec_rl   (rec_rl),
        .busy     (busy),
        .strb_rd  (strb_rd),
        .strb_wr  (strb_wr),
        .done     (done)
    );
endmodule

// File: rtl/pio_timer_chk.sv
module pio_timer_chk #(
    parameter int MAX_CYC = 37
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic strb_rd,
    input logic strb_wr,
    input logic done
);
    localparam int RUN_W = $clog2(MAX_CYC + 2) + 1;

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + RUN_W'(1);
        else           run <= '0;
    end

    // R11
    strobe_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb_rd && strb_wr));

    // R11
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_rd || strb_wr) |-> busy);

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !strb_rd && !strb_wr));

    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !strb_rd && !strb_wr));

    // R2
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    // R3
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strb_rd) || $rose(strb_wr)) |-> $past(busy));

    // R5
    recovery_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(strb_rd || strb_wr));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_W'(MAX_CYC));
endmodule

bind pio_cycle_timer pio_timer_chk #(
    .MAX_CYC((2**SETUP_W) + (2**DATA_W) + (2**REC_W) + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .strb_rd (strb_rd),
    .strb_wr (strb_wr),
    .done    (done)
);

// File: tb/pio_cycle_timer_tb.sv
module pio_cycle_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_sel = 1'b0;
    logic        req_wr = 1'b0;
    logic        swap_sets = 1'b0;
    logic [1:0]  setup_d0 = 2'd0;
    logic [1:0]  setup_d1 = 2'd0;
    logic [15:0] tset_a = 16'h0000;
    logic [15:0] tset_b = 16'h0000;
    logic        busy, strb_rd, strb_wr, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pio_cycle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_sel(req_sel), .req_wr(req_wr),
        .swap_sets(swap_sets), .setup_d0(setup_d0), .setup_d1(setup_d1),
        .tset_a(tset_a), .tset_b(tset_b),
        .busy(busy), .strb_rd(strb_rd), .strb_wr(strb_wr), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Build a set: read data, read recovery, write data, write recovery fields.
    function automatic logic [15:0] mkset(input int rd, input int rr, input int wd, input int wr);
        return {4'(rd), 4'(rr), 4'(wd), 4'(wr)};
    endfunction

    // Samples at negedges while busy; classifies each clock by phase.
    task automatic measure(output int a, output int d, output int r, output int nrd,
                           output int nwr, output int ndone, output int lastd, output int both);
        bit seen = 0;
        int guard = 0;
        a = 0; d = 0; r = 0; nrd = 0; nwr = 0; ndone = 0; lastd = 0; both = 0;
        while (busy && guard < 100) begin
            if (strb_rd && strb_wr) both++;
            if (strb_rd || strb_wr) begin
                d++; seen = 1;
                if (strb_rd) nrd++;
                if (strb_wr) nwr++;
            end else if (!seen) a++;
            else r++;
            if (done) ndone++;
            lastd = done;
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic check_meas(input string tag, input bit wr, input int ea, input int ed, input int er,
                              input int a, input int d, input int r, input int nrd, input int nwr,
                              input int ndone, input int lastd, input int both);
        chk(a == ea, {tag, " R3 setup clocks"}, a, ea);
        chk(d == ed, {tag, " R4 data clocks"}, d, ed);
        chk(r == er, {tag, " R5 recovery clocks"}, r, er);
        chk((wr ? nwr : nrd) == ed, {tag, " R7 strobe direction"}, wr ? nwr : nrd, ed);
        chk((wr ? nrd : nwr) == 0, {tag, " R4 wrong strobe"}, wr ? nrd : nwr, 0);
        chk(both == 0, {tag, " R11 strobes overlap"}, both, 0);
        chk(ndone == 1 && lastd == 1, {tag, " R8 done once at end"}, ndone * 10 + lastd, 11);
    endtask

    task automatic xfer(input string tag, input bit drv, input bit wr,
                        input int ea, input int ed, input int er);
        int a, d, r, nrd, nwr, ndone, lastd, both;
        @(negedge clk);
        req = 1; req_sel = drv; req_wr = wr;
        @(negedge clk);
        chk(busy == 1, {tag, " R2 busy after accept"}, busy, 1);
        req = 0;
        measure(a, d, r, nrd, nwr, ndone, lastd, both);
        check_meas(tag, wr, ea, ed, er, a, d, r, nrd, nwr, ndone, lastd, both);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        chk({busy, strb_rd, strb_wr, done} == 4'b0, "R1 reset state", {busy, strb_rd, strb_wr, done}, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy || strb_rd || strb_wr || done) begin
                chk(0, "R1 idle without request", busy, 0);
                break;
            end
        end
        chk(busy == 0, "R1 still idle", busy, 0);
    endtask

    task automatic t_basic_read();
        swap_sets = 0; setup_d0 = 2'd1; setup_d1 = 2'd0;
        tset_a = mkset(3, 1, 9, 9); tset_b = mkset(7, 7, 7, 7);
        xfer("read d0 R6", 0, 0, 2, 4, 3);
    endtask

    task automatic t_min_write();
        swap_sets = 0; setup_d0 = 2'd0; setup_d1 = 2'd3;
        tset_a = mkset(5, 5, 5, 5); tset_b = mkset(6, 6, 0, 0);
        xfer("write d1 min R6", 1, 1, 4, 1, 2);
        // shared setup applies to drive 0 too
        xfer("write d0 shared setup R3", 0, 1, 4, 6, 7);
    endtask

    task automatic t_swap();
        swap_sets = 1; setup_d0 = 2'd2; setup_d1 = 2'd1;
        tset_a = mkset(1, 1, 1, 1); tset_b = mkset(4, 2, 8, 3);
        xfer("swap read d0 R6", 0, 0, 3, 5, 4);
        xfer("swap write d1 R6", 1, 1, 3, 2, 3);
        swap_sets = 0;
    endtask

    task automatic t_max();
        setup_d0 = 2'd0; setup_d1 = 2'd0;
        tset_a = mkset(15, 15, 0, 15); tset_b = 16'h0;
        xfer("max read R4 R5", 0, 0, 1, 16, 17);
    endtask

    task automatic t_held_off();
        int a, d, r, nrd, nwr, ndone, lastd, both;
        setup_d0 = 2'd1; setup_d1 = 2'd1; swap_sets = 0;
        tset_a = mkset(2, 2, 2, 1); tset_b = mkset(3, 0, 5, 5);
        @(negedge clk);
        req = 1; req_sel = 0; req_wr = 1;
        @(negedge clk);
        chk(busy == 1, "R9 first accepted", busy, 1);
        req_sel = 1; req_wr = 0;   // request stays high for the second transfer
        measure(a, d, r, nrd, nwr, ndone, lastd, both);
        check_meas("held first R9", 1, 2, 3, 3, a, d, r, nrd, nwr, ndone, lastd, both);
        chk(busy == 0 && !strb_rd && !strb_wr, "R9 one idle gap", busy, 0);
        @(negedge clk);
        chk(busy == 1, "R9 pending request started", busy, 1);
        req = 0;
        measure(a, d, r, nrd, nwr, ndone, lastd, both);
        check_meas("held second R9", 0, 2, 4, 2, a, d, r, nrd, nwr, ndone, lastd, both);
    endtask

    task automatic t_snapshot();
        int a, d, r, nrd, nwr, ndone, lastd, both;
        setup_d0 = 2'd1; setup_d1 = 2'd0; swap_sets = 0;
        tset_a = mkset(0, 0, 4, 2); tset_b = mkset(0, 0, 0, 0);
        @(negedge clk);
        req = 1; req_sel = 0; req_wr = 1;
        @(negedge clk);
        req = 0;
        tset_a = mkset(15, 15, 15, 15); setup_d0 = 2'd3; swap_sets = 1;
        measure(a, d, r, nrd, nwr, ndone, lastd, both);
        check_meas("snapshot R10", 1, 2, 5, 4, a, d, r, nrd, nwr, ndone, lastd, both);
        swap_sets = 0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_idle();
        t_basic_read();
        t_min_write();
        t_swap();
        t_max();
        t_held_off();
        t_snapshot();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule